// File: doc/BRIEF.md
# Dual-Mode Fetch Word Splitter

This block sits between a 32-bit instruction fetch port and the decode stage of a core that runs in two modes. In wide mode, each accepted fetch word goes to decode as one 32-bit instruction. In narrow mode, each word carries two 16-bit instructions. The lower halfword is issued to the narrow-to-wide expander in the cycle the word is accepted. The upper halfword is kept in a one-entry register and issued in the following cycle. During that second cycle the block does not accept a new word, so in narrow mode it takes one fetch word for every two issued instructions.

The fetch side always supplies full words and knows nothing about the modes. The mode flag alone decides how a word is read, and it changes only when a mode-switch instruction is issued.

- A dedicated 32-bit switch word moves execution into narrow mode.
- A dedicated 16-bit switch halfword moves it back to wide mode.
- Narrow runs are padded to an even length with a narrow no-op. The block issues that no-op like any other halfword.
- A flush or a taken branch empties the halfword register. If the branch target has address bit 1 set, only the upper half of the first word fetched afterwards is issued.

Top module: `hw_split_top`

## Requirements
- R1: After reset the mode is wide (`narrow_mode_o`=0), no instruction is issued, and `fetch_rdy_o` is 1 when neither stall nor flush is asserted.
- R2: In wide mode, a word accepted while `fetch_valid_i`=1 and `fetch_rdy_o`=1 is issued in that same cycle with `issue_narrow_o`=0 and `issue_instr_o` equal to the word. `fetch_rdy_o` stays 1 in every unstalled cycle.
- R3: In narrow mode, an accepted word issues bits 15:0 in the same cycle and bits 31:16 in the next cycle. Both have `issue_narrow_o`=1 and are zero-extended into `issue_instr_o`. `fetch_rdy_o` is 0 during the second cycle.
- R4: Issuing the wide switch word (parameter `WIDE_SWITCH`, default 32'hFC00_0001) in wide mode puts the block into narrow mode from the next cycle on.
- R5: Issuing the narrow switch halfword (parameter `NARROW_SWITCH`, default 16'hE8E0) from the upper half returns the block to wide mode from the next cycle on.
- R6: When the narrow switch halfword is in bits 15:0, the upper halfword (a padding no-op) is never issued. The next cycle accepts a new word and decodes it in wide mode.
- R7: A narrow no-op halfword (16'h6500 in the bench) is issued like any halfword and does not change the mode.
- R8: While `stall_i`=1 and `flush_i`=0, nothing is issued, `fetch_rdy_o` is 0, and the mode and the held halfword keep their values. A held upper halfword is issued once the stall ends.
- R9: `flush_i`=1 issues nothing, accepts no word, and discards any held halfword. The next unstalled cycle accepts a new word.
- R10: A flush with `flush_odd_i`=1 makes the first word accepted afterwards in narrow mode issue only bits 31:16. `fetch_rdy_o` is 1 again in the following cycle.
- R11: With no held halfword and `fetch_valid_i`=0, `issue_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_valid_i | input | 1 | Fetch word available |
| fetch_data_i | input | 32 | Fetched word |
| fetch_rdy_o | output | 1 | Word is taken this cycle when valid |
| stall_i | input | 1 | Decode cannot accept; hold all state |
| flush_i | input | 1 | Flush or taken branch redirect |
| flush_odd_i | input | 1 | Redirect target has address bit 1 set |
| issue_valid_o | output | 1 | Instruction presented to decode |
| issue_narrow_o | output | 1 | Issued instruction is 16-bit, goes through the expander |
| issue_instr_o | output | 32 | Issued instruction, halfwords zero-extended |
| narrow_mode_o | output | 1 | Current mode, 1 = narrow |

## Verification
The hardest state to reach is a held upper halfword that meets a stall or a flush in the cycle after its word was accepted. A stall must keep that halfword, while a flush must discard it, and the result is only visible in the cycle after. The stimulus first enters narrow mode with the switch word. It then presents a word and applies the stall or flush in the very next cycle. A flush with the odd-address flag is followed by a word whose upper half is the narrow switch, to check the skip path and the mode return together. A behavioural queue model in the bench predicts every output on every cycle.

// File: rtl/hw_split_pkg.sv
package hw_split_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = WORD_W / 2;

  typedef enum logic {
    MODE_WIDE   = 1'b0,
    MODE_NARROW = 1'b1
  } mode_e;
endpackage

// File: rtl/hw_split_mode.sv
module hw_split_mode
  import hw_split_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  adv_i,
  input  logic  to_narrow_i,
  input  logic  to_wide_i,
  output mode_e mode_o
);
  mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      mode_q <= MODE_WIDE;
    else if (adv_i && to_narrow_i)    mode_q <= MODE_NARROW;
    else if (adv_i && to_wide_i)      mode_q <= MODE_WIDE;
  end

  assign mode_o = mode_q;

  // R8
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(mode_q));
endmodule

// File: rtl/hw_split_latch.sv
module hw_split_latch
  import hw_split_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              flush_odd_i,
  input  logic              adv_i,
  input  logic              take_i,
  input  logic              load_i,
  input  logic [HALF_W-1:0] hw_i,
  input  logic              word_take_i,
  output logic              hold_vld_o,
  output logic [HALF_W-1:0] hold_hw_o,
  output logic              skip_low_o
);
  logic              vld_q;
  logic [HALF_W-1:0] hw_q;
  logic              skip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      hw_q   <= '0;
      skip_q <= 1'b0;
    end else if (flush_i) begin
      vld_q  <= 1'b0;
      skip_q <= flush_odd_i;
    end else if (adv_i) begin
      if (take_i) begin
        vld_q <= 1'b0;
      end else if (load_i) begin
        vld_q <= 1'b1;
        hw_q  <= hw_i;
      end
      if (word_take_i) skip_q <= 1'b0;
    end
  end

  assign hold_vld_o = vld_q;
  assign hold_hw_o  = hw_q;
  assign skip_low_o = skip_q;

  // R9
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !vld_q);
  // R8
  stall_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !flush_i) |=> ($stable(vld_q) && $stable(hw_q)));
endmodule

// File: rtl/hw_split_issue.sv
module hw_split_issue
  import hw_split_pkg::*;
#(
  parameter logic [WORD_W-1:0] WIDE_SWITCH   = 32'hFC00_0001,
  parameter logic [HALF_W-1:0] NARROW_SWITCH = 16'hE8E0
) (
  input  logic              adv_i,
  input  mode_e             mode_i,
  input  logic              hold_vld_i,
  input  logic [HALF_W-1:0] hold_hw_i,
  input  logic              skip_low_i,
  input  logic              fetch_valid_i,
  input  logic [WORD_W-1:0] fetch_data_i,
  output logic              issue_valid_o,
  output logic              issue_narrow_o,
  output logic [WORD_W-1:0] issue_instr_o,
  output logic              take_o,
  output logic              load_o,
  output logic              word_take_o,
  output logic              to_narrow_o,
  output logic              to_wide_o
);
  logic [HALF_W-1:0] lo_hw, hi_hw;
  assign lo_hw = fetch_data_i[HALF_W-1:0];
  assign hi_hw = fetch_data_i[WORD_W-1:HALF_W];

  always_comb begin
    issue_valid_o  = 1'b0;
    issue_narrow_o = 1'b0;
    issue_instr_o  = '0;
    take_o         = 1'b0;
    load_o         = 1'b0;
    word_take_o    = 1'b0;
    to_narrow_o    = 1'b0;
    to_wide_o      = 1'b0;
    if (adv_i) begin
      if (hold_vld_i) begin
        issue_valid_o  = 1'b1;
        issue_narrow_o = 1'b1;
        issue_instr_o  = {{HALF_W{1'b0}}, hold_hw_i};
        take_o         = 1'b1;
        to_wide_o      = (hold_hw_i == NARROW_SWITCH);
      end else if (fetch_valid_i) begin
        word_take_o   = 1'b1;
        issue_valid_o = 1'b1;
        if (mode_i == MODE_WIDE) begin
          issue_instr_o = fetch_data_i;
          to_narrow_o   = (fetch_data_i == WIDE_SWITCH);
        end else begin
          issue_narrow_o = 1'b1;
          if (skip_low_i) begin
            issue_instr_o = {{HALF_W{1'b0}}, hi_hw};
            to_wide_o     = (hi_hw == NARROW_SWITCH);
          end else begin
            issue_instr_o = {{HALF_W{1'b0}}, lo_hw};
            // switch in low half: upper is padding, drop it
            if (lo_hw == NARROW_SWITCH) to_wide_o = 1'b1;
            else                        load_o    = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/hw_split_top.sv
module hw_split_top
  import hw_split_pkg::*;
#(
  parameter logic [WORD_W-1:0] WIDE_SWITCH   = 32'hFC00_0001,
  parameter logic [HALF_W-1:0] NARROW_SWITCH = 16'hE8E0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_valid_i,
  input  logic [WORD_W-1:0] fetch_data_i,
  output logic              fetch_rdy_o,
  input  logic              stall_i,
  input  logic              flush_i,
  input  logic              flush_odd_i,
  output logic              issue_valid_o,
  output logic              issue_narrow_o,
  output logic [WORD_W-1:0] issue_instr_o,
  output logic              narrow_mode_o
);
  mode_e             mode;
  logic              adv, hold_vld, skip_low;
  logic [HALF_W-1:0] hold_hw;
  logic              take, load, word_take, to_narrow, to_wide;

  assign adv         = !stall_i && !flush_i;
  assign fetch_rdy_o = adv && !hold_vld;

  hw_split_mode u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .adv_i       (adv),
    .to_narrow_i (to_narrow),
    .to_wide_i   (to_wide),
    .mode_o      (mode)
  );

  hw_split_latch u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .flush_odd_i (flush_odd_i),
    .adv_i       (adv),
    .take_i      (take),
    .load_i      (load),
    .hw_i        (fetch_data_i[WORD_W-1:HALF_W]),
    .word_take_i (word_take),
    .hold_vld_o  (hold_vld),
    .hold_hw_o   (hold_hw),
    .skip_low_o  (skip_low)
  );

  hw_split_issue #(
    .WIDE_SWITCH   (WIDE_SWITCH),
    .NARROW_SWITCH (NARROW_SWITCH)
  ) u_issue (
    .adv_i          (adv),
    .mode_i         (mode),
    .hold_vld_i     (hold_vld),
    .hold_hw_i      (hold_hw),
    .skip_low_i     (skip_low),
    .fetch_valid_i  (fetch_valid_i),
    .fetch_data_i   (fetch_data_i),
    .issue_valid_o  (issue_valid_o),
    .issue_narrow_o (issue_narrow_o),
    .issue_instr_o  (issue_instr_o),
    .take_o         (take),
    .load_o         (load),
    .word_take_o    (word_take),
    .to_narrow_o    (to_narrow),
    .to_wide_o      (to_wide)
  );

  assign narrow_mode_o = (mode == MODE_NARROW);

  // R3
  held_blocks_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_vld |-> !fetch_rdy_o);
  // R3
  held_only_narrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_vld |-> narrow_mode_o);
  // R2
  wide_issue_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && !issue_narrow_o) |-> !narrow_mode_o);
  // R4
  enter_narrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(narrow_mode_o) |-> $past(fetch_valid_i && fetch_rdy_o && fetch_data_i == WIDE_SWITCH));
  // R11
  idle_no_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_vld && !fetch_valid_i) |-> !issue_valid_o);
endmodule

// File: tb/hw_split_top_tb_top.sv
module hw_split_top_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] WSW = 32'hFC00_0001;
  localparam logic [15:0] NSW = 16'hE8E0;
  localparam logic [15:0] NOP = 16'h6500;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_data = '0;
  logic        fetch_rdy;
  logic        stall = 1'b0, flush = 1'b0, flush_odd = 1'b0;
  logic        iv, inr, nmode;
  logic [31:0] iinstr;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;

  // behavioural model state
  bit          m_mode = 1'b0;
  logic [15:0] m_hold[$];
  bit          m_skip = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hw_split_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_valid_i(fetch_valid), .fetch_data_i(fetch_data), .fetch_rdy_o(fetch_rdy),
    .stall_i(stall), .flush_i(flush), .flush_odd_i(flush_odd),
    .issue_valid_o(iv), .issue_narrow_o(inr), .issue_instr_o(iinstr),
    .narrow_mode_o(nmode)
  );

  task automatic fin();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
      fin();
    end
  end

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] d, input logic st,
                      input logic fl, input logic fo, input string tag);
    logic e_rdy, e_v, e_n;
    logic [31:0] e_i;
    logic [15:0] h;
    bit was_skip;
    @(negedge clk);
    fetch_valid = v; fetch_data = d; stall = st; flush = fl; flush_odd = fo;
    #1;
    e_rdy = !fl && !st && (m_hold.size() == 0);
    e_v = 1'b0; e_n = 1'b0; e_i = '0;
    if (!fl && !st) begin
      if (m_hold.size() != 0) begin
        e_v = 1'b1; e_n = 1'b1; e_i = {16'h0, m_hold[0]};
      end else if (v) begin
        e_v = 1'b1;
        if (!m_mode) e_i = d;
        else begin
          e_n = 1'b1;
          e_i = m_skip ? {16'h0, d[31:16]} : {16'h0, d[15:0]};
        end
      end
    end
    vectors++;
    cmp(tag, "fetch_rdy", {31'b0, fetch_rdy}, {31'b0, e_rdy});
    cmp(tag, "issue_valid", {31'b0, iv}, {31'b0, e_v});
    cmp(tag, "narrow_mode", {31'b0, nmode}, {31'b0, m_mode});
    if (e_v) begin
      cmp(tag, "issue_narrow", {31'b0, inr}, {31'b0, e_n});
      cmp(tag, "issue_instr", iinstr, e_i);
    end
    @(posedge clk);
    if (fl) begin
      m_hold.delete();
      m_skip = fo;
    end else if (!st) begin
      if (m_hold.size() != 0) begin
        h = m_hold.pop_front();
        if (h == NSW) m_mode = 1'b0;
      end else if (v) begin
        was_skip = m_skip;
        m_skip = 1'b0;
        if (!m_mode) begin
          if (d == WSW) m_mode = 1'b1;
        end else if (was_skip) begin
          if (d[31:16] == NSW) m_mode = 1'b0;
        end else if (d[15:0] == NSW) m_mode = 1'b0;
        else m_hold.push_back(d[31:16]);
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    step(0, '0, 0, 0, 0, "R1");
    step(0, '0, 0, 0, 0, "R11");
    // R2 wide stream
    step(1, 32'h1234_5678, 0, 0, 0, "R2");
    step(1, 32'hA5A5_0F0F, 0, 0, 0, "R2");
    step(0, '0, 0, 0, 0, "R11");
    // R8 stall in wide mode with switch word present
    step(1, WSW, 1, 0, 0, "R8");
    // R4 enter narrow
    step(1, WSW, 0, 0, 0, "R4");
    // R3 narrow pairs
    step(1, 32'h2222_1111, 0, 0, 0, "R3");
    step(1, 32'h9999_9999, 0, 0, 0, "R3");
    step(1, 32'h4444_3333, 0, 0, 0, "R3");
    step(0, '0, 0, 0, 0, "R3");
    step(0, '0, 0, 0, 0, "R11");
    // R7 padding no-op upper
    step(1, {NOP, 16'h5555}, 0, 0, 0, "R7");
    step(0, '0, 0, 0, 0, "R7");
    // R8 stall while upper held
    step(1, 32'h7777_6666, 0, 0, 0, "R8");
    step(1, 32'h0BAD_0BAD, 1, 0, 0, "R8");
    step(1, 32'h0BAD_0BAD, 1, 0, 0, "R8");
    step(0, '0, 0, 0, 0, "R8");
    // R9 flush while upper held
    step(1, 32'h8888_1357, 0, 0, 0, "R9");
    step(1, 32'hDEAD_BEEF, 0, 1, 0, "R9");
    step(1, 32'h2468_1234, 0, 0, 0, "R9");
    step(0, '0, 0, 0, 0, "R9");
    // R10 odd redirect, upper only
    step(0, '0, 0, 1, 1, "R10");
    step(1, 32'h3C3C_FFFF, 0, 0, 0, "R10");
    step(1, 32'h5A5A_4B4B, 0, 0, 0, "R10");
    step(0, '0, 0, 0, 0, "R10");
    // R6 switch in low half, padding dropped
    step(1, {NOP, NSW}, 0, 0, 0, "R6");
    step(1, 32'hCAFE_F00D, 0, 0, 0, "R6");
    // R5 switch in upper half
    step(1, WSW, 0, 0, 0, "R5");
    step(1, {NSW, 16'h1212}, 0, 0, 0, "R5");
    step(0, '0, 0, 0, 0, "R5");
    step(1, 32'h0F0F_F0F0, 0, 0, 0, "R5");
    // R10 odd redirect with switch in upper half
    step(1, WSW, 0, 0, 0, "R10");
    step(0, '0, 0, 1, 1, "R10");
    step(1, {NSW, 16'h7171}, 0, 0, 0, "R10");
    step(1, 32'h1357_9BDF, 0, 0, 0, "R10");
    // R10 odd flag ignored in wide mode
    step(0, '0, 0, 1, 1, "R10");
    step(1, 32'h6060_7070, 0, 0, 0, "R10");
    fin();
  end
endmodule